// File: doc/BRIEF.md
# UART External FIFO Data Path

This block sits between a host register window and a conventional UART core. It can route every character through a pair of 16-entry FIFOs, one per direction, or pass host accesses to the UART directly. Host reads and writes at the data offset either pop the receive FIFO and push the transmit FIFO, or reach the UART byte handshake straight away when the FIFOs are disabled.

Two bits in the modem-control register block the transfers between each FIFO and the UART, one bit per direction. A swap option inverts the upper address bit of both storage arrays, so the two 8-byte halves of the 16-byte space change places. Automatic hardware flow control drives RTS from the receive fill level and stops transmit transfers while CTS is low.

A write to the flush offset empties both FIFOs. The serializer and any interrupt generation live outside this block.

Top module: `uart_xfifo_path`

## Requirements
- R1: After reset the mode and modem-control registers read 0x00, both FIFOs are empty, `uart_tx_valid` is 0 and `rts` is 1.
- R2: With the FIFO enable clear, a host write at offset 0x8 drives `uart_tx_valid`=1 and `uart_tx_data`=the written byte in the same cycle. A host read at offset 0x8 returns `uart_rx_data` and drives `uart_rx_ready`=1 in the same cycle.
- R3: With the FIFO enable set, bytes written at offset 0x8 reach the UART transmit handshake in write order. Bytes accepted from the UART receive handshake are returned by reads at offset 0x8 in arrival order. A write to a full (16-entry) transmit FIFO is dropped. A read of an empty receive FIFO returns 0x00.
- R4: The mode register at offset 0x0 holds bit0 = half swap, bit2 = FIFO enable and bit3 = auto flow control. Bit1 always reads 0 and the other bits read 0.
- R5: While the swap bit is set, storage address bit3 is inverted on both the write side and the read side. If 16 bytes are written with swap clear and then read with swap set, they come out as entries 8..15 followed by entries 0..7.
- R6: Modem-control register (offset 0xC) bit3 = 1 holds `uart_rx_ready` low in FIFO mode, so no received byte enters the receive FIFO.
- R7: Modem-control bit2 = 1 holds `uart_tx_valid` low in FIFO mode, so the transmit FIFO does not feed the UART. Clearing the bit resumes delivery.
- R8: Any host write at offset 0x2 empties both FIFOs. The following read at offset 0x8 returns 0x00 and `uart_tx_valid` stays low.
- R9: With auto flow control on, `rts` goes low one cycle after the receive FIFO holds 14 or more entries. It goes high one cycle after the FIFO holds fewer than 8 entries, and keeps its value in between. With auto flow control off, `rts` is 1.
- R10: With auto flow control on in FIFO mode, `uart_tx_valid` is 0 while `cts` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| uart_tx_valid | output | 1 | Byte offered to UART transmitter |
| uart_tx_ready | input | 1 | UART transmitter accepts the byte |
| uart_tx_data | output | 8 | Byte to UART transmitter |
| uart_rx_valid | input | 1 | UART receiver offers a byte |
| uart_rx_ready | output | 1 | Block accepts the received byte |
| uart_rx_data | input | 8 | Byte from UART receiver |
| cts | input | 1 | Clear to send, high = remote may receive |
| rts | output | 1 | Request to send, high = block may receive |

## Verification
The data path is exercised in four ways, each separating a different fault:
- Short bursts with the UART consumer stalled, then released. These separate ordering faults from handshake faults.
- A 17-byte burst into the transmit FIFO. This shows whether the full condition drops the extra byte or overwrites storage.
- A full 16-byte receive load read back after the swap bit is toggled. This tells a correct address-bit inversion apart from no swap or a swap applied on only one side.
- Receive fill levels stepped across 13, 14, 8 and 7 entries. These locate both RTS thresholds and the hysteresis between them.

// File: rtl/uart_xfifo_path.sv
module uart_xfifo_path #(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int RTS_HI = 14,
  parameter int RTS_LO = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [3:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          uart_tx_valid,
  input  logic          uart_tx_ready,
  output logic [DW-1:0] uart_tx_data,
  input  logic          uart_rx_valid,
  output logic          uart_rx_ready,
  input  logic [DW-1:0] uart_rx_data,
  input  logic          cts,
  output logic          rts
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [3:0] OFS_MODE  = 4'h0;
  localparam logic [3:0] OFS_FLUSH = 4'h2;
  localparam logic [3:0] OFS_DATA  = 4'h8;
  localparam logic [3:0] OFS_MCR   = 4'hC;

  logic swap, fifo_en, auto_fc, tx_gate, rx_gate, rts_q;
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp, tx_cnt, rx_cnt;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];

  wire wr_mode  = host_wr && host_addr == OFS_MODE;
  wire wr_mcr   = host_wr && host_addr == OFS_MCR;
  wire wr_flush = host_wr && host_addr == OFS_FLUSH;
  wire wr_data  = host_wr && host_addr == OFS_DATA;
  wire rd_data  = host_rd && host_addr == OFS_DATA;

  wire [AW-1:0] smask = {swap, {(AW-1){1'b0}}};
  assign tx_cnt = tx_wp - tx_rp;
  assign rx_cnt = rx_wp - rx_rp;
  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;
  wire tx_full  = tx_cnt == PW'(DEPTH);
  wire rx_full  = rx_cnt == PW'(DEPTH);

  wire tx_push = fifo_en && wr_data && !tx_full;
  wire tx_pop  = fifo_en && uart_tx_valid && uart_tx_ready;
  wire rx_push = fifo_en && uart_rx_valid && uart_rx_ready;
  wire rx_pop  = fifo_en && rd_data && !rx_empty;

  wire [AW-1:0] tx_waddr = tx_wp[AW-1:0] ^ smask;
  wire [AW-1:0] tx_raddr = tx_rp[AW-1:0] ^ smask;
  wire [AW-1:0] rx_waddr = rx_wp[AW-1:0] ^ smask;
  wire [AW-1:0] rx_raddr = rx_rp[AW-1:0] ^ smask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {swap, fifo_en, auto_fc} <= '0;
      {tx_gate, rx_gate} <= '0;
    end else begin
      if (wr_mode) begin
        swap    <= host_wdata[0];
        fifo_en <= host_wdata[2];
        auto_fc <= host_wdata[3];
      end
      if (wr_mcr) begin
        tx_gate <= host_wdata[2];
        rx_gate <= host_wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else if (wr_flush) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push && !wr_flush) tx_mem[tx_waddr] <= host_wdata;
    if (rx_push && !wr_flush) rx_mem[rx_waddr] <= uart_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b1;
    else if (rx_cnt >= PW'(RTS_HI)) rts_q <= 1'b0;
    else if (rx_cnt < PW'(RTS_LO)) rts_q <= 1'b1;
  end

  assign rts = !auto_fc || rts_q;
  assign uart_tx_valid = fifo_en ? (!tx_empty && !tx_gate && (!auto_fc || cts)) : wr_data;
  assign uart_tx_data  = fifo_en ? tx_mem[tx_raddr] : host_wdata;
  assign uart_rx_ready = fifo_en ? (!rx_full && !rx_gate) : rd_data;

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_MODE: host_rdata = DW'({auto_fc, fifo_en, 1'b0, swap});
      OFS_MCR:  host_rdata = DW'({rx_gate, tx_gate, 2'b00});
      OFS_DATA: host_rdata = fifo_en ? (rx_empty ? '0 : rx_mem[rx_raddr]) : uart_rx_data;
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_xfifo_path_chk.sv
module uart_xfifo_path_chk #(
  parameter int AW     = 4,
  parameter int RTS_HI = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic [3:0]    host_addr,
  input logic          fifo_en,
  input logic          auto_fc,
  input logic          tx_gate,
  input logic          rx_gate,
  input logic          cts,
  input logic          uart_tx_valid,
  input logic          uart_rx_ready,
  input logic          rts,
  input logic [AW:0]   tx_cnt,
  input logic [AW:0]   rx_cnt
);
  localparam int DEPTH = 1 << AW;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (AW+1)'(DEPTH) && rx_cnt <= (AW+1)'(DEPTH));

  assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && rx_gate |-> !uart_rx_ready);

  assert_tx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && tx_gate |-> !uart_tx_valid);

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 4'h2 |=> tx_cnt == '0 && rx_cnt == '0);

  assert_rts_high_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    auto_fc && rx_cnt >= (AW+1)'(RTS_HI) |=> (!rts || !auto_fc));

  assert_cts_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && auto_fc && !cts |-> !uart_tx_valid);
endmodule

bind uart_xfifo_path uart_xfifo_path_chk #(.AW(AW), .RTS_HI(RTS_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .fifo_en(fifo_en), .auto_fc(auto_fc), .tx_gate(tx_gate), .rx_gate(rx_gate),
  .cts(cts), .uart_tx_valid(uart_tx_valid), .uart_rx_ready(uart_rx_ready),
  .rts(rts), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_uart_xfifo_path.sv
module tb_uart_xfifo_path;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [3:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic uart_tx_valid, uart_tx_ready = 0;
  logic [7:0] uart_tx_data;
  logic uart_rx_valid = 0, uart_rx_ready;
  logic [7:0] uart_rx_data = 0;
  logic cts = 1, rts;

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  uart_xfifo_path dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && uart_tx_valid && uart_tx_ready) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected tx byte", uart_tx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(uart_tx_data == e, "R3 tx order", uart_tx_data, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    host_rd = 1; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(posedge clk); #1;
    uart_rx_valid = 1; uart_rx_data = b;
    @(posedge clk); #1;
    uart_rx_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(2);
    rst_n = 1;
    idle(1);
    check(rts == 1, "R1 rts after reset", rts, 1);
    check(uart_tx_valid == 0, "R1 tx_valid after reset", uart_tx_valid, 0);
    hread(4'h0, d); check(d == 8'h00, "R1 mode reset", d, 0);
    hread(4'hC, d); check(d == 8'h00, "R1 mcr reset", d, 0);

    // R2 bypass
    uart_tx_ready = 1;
    exp_q.push_back(8'h5A);
    @(posedge clk); #1;
    host_wr = 1; host_addr = 4'h8; host_wdata = 8'h5A;
    #1 check(uart_tx_valid == 1 && uart_tx_data == 8'h5A, "R2 bypass write", uart_tx_data, 8'h5A);
    @(posedge clk); #1; host_wr = 0;
    uart_rx_data = 8'h3C;
    @(posedge clk); #1;
    host_rd = 1; host_addr = 4'h8;
    #1 check(host_rdata == 8'h3C && uart_rx_ready == 1, "R2 bypass read", host_rdata, 8'h3C);
    @(posedge clk); #1; host_rd = 0;
    idle(1);
    check(uart_rx_ready == 0, "R2 rx_ready idle", uart_rx_ready, 0);

    // R4 mode fields
    hwrite(4'h0, 8'hFF);
    hread(4'h0, d); check(d == 8'h0D, "R4 mode readback bit1 zero", d, 8'h0D);
    hwrite(4'h0, 8'h04);

    // R3 tx order
    uart_tx_ready = 0;
    for (int i = 0; i < 3; i++) begin hwrite(4'h8, 8'h10 + 8'(i)); exp_q.push_back(8'h10 + 8'(i)); end
    check(uart_tx_valid == 1, "R3 tx_valid with data", uart_tx_valid, 1);
    uart_tx_ready = 1; idle(8);
    check(exp_q.size() == 0, "R3 tx drained", exp_q.size(), 0);
    uart_tx_ready = 0;
    for (int i = 0; i < 17; i++) begin
      hwrite(4'h8, 8'h20 + 8'(i));
      if (i < 16) exp_q.push_back(8'h20 + 8'(i));
    end
    uart_tx_ready = 1; idle(30);
    check(exp_q.size() == 0 && uart_tx_valid == 0, "R3 full tx drops 17th", exp_q.size(), 0);

    // R7 tx gate
    uart_tx_ready = 0;
    hwrite(4'h8, 8'hA1); hwrite(4'h8, 8'hA2);
    exp_q.push_back(8'hA1); exp_q.push_back(8'hA2);
    hwrite(4'hC, 8'h04);
    uart_tx_ready = 1; idle(5);
    check(uart_tx_valid == 0 && exp_q.size() == 2, "R7 tx gated", exp_q.size(), 2);
    hwrite(4'hC, 8'h00); idle(5);
    check(exp_q.size() == 0, "R7 tx resumes", exp_q.size(), 0);

    // R10 cts hold
    hwrite(4'h0, 8'h0C);
    cts = 0;
    hwrite(4'h8, 8'hB7); exp_q.push_back(8'hB7);
    idle(3);
    check(uart_tx_valid == 0 && exp_q.size() == 1, "R10 cts low holds tx", uart_tx_valid, 0);
    cts = 1; idle(3);
    check(exp_q.size() == 0, "R10 cts high releases", exp_q.size(), 0);

    // R3 rx order
    hwrite(4'h0, 8'h04);
    for (int i = 0; i < 3; i++) rx_push(8'h60 + 8'(i));
    for (int i = 0; i < 3; i++) begin
      hread(4'h8, d); check(d == 8'h60 + 8'(i), "R3 rx order", d, 8'h60 + i);
    end
    hread(4'h8, d); check(d == 8'h00, "R3 empty rx read", d, 0);

    // R9 flow control
    hwrite(4'h0, 8'h0C);
    for (int i = 0; i < 13; i++) rx_push(8'h40 + 8'(i));
    idle(2); check(rts == 1, "R9 rts high at 13", rts, 1);
    rx_push(8'h4D);
    idle(2); check(rts == 0, "R9 rts low at 14", rts, 0);
    for (int i = 0; i < 6; i++) begin
      hread(4'h8, d); check(d == 8'h40 + 8'(i), "R9 rx data", d, 8'h40 + i);
    end
    idle(2); check(rts == 0, "R9 rts held at 8", rts, 0);
    hread(4'h8, d); check(d == 8'h46, "R9 rx data", d, 8'h46);
    idle(2); check(rts == 1, "R9 rts high at 7", rts, 1);
    hwrite(4'h0, 8'h04);
    check(rts == 1, "R9 rts with auto off", rts, 1);
    for (int i = 7; i < 14; i++) begin
      hread(4'h8, d); check(d == 8'h40 + 8'(i), "R9 rx tail", d, 8'h40 + i);
    end

    // R6 rx gate
    hwrite(4'hC, 8'h08);
    @(posedge clk); #1; uart_rx_valid = 1; uart_rx_data = 8'hEE;
    #1 check(uart_rx_ready == 0, "R6 rx gated", uart_rx_ready, 0);
    idle(3); uart_rx_valid = 0;
    hread(4'h8, d); check(d == 8'h00, "R6 nothing received", d, 0);
    hwrite(4'hC, 8'h00);

    // R5 swap
    hwrite(4'h2, 8'h00);
    for (int i = 0; i < 16; i++) rx_push(8'h80 + 8'(i));
    check(uart_rx_ready == 0, "R5 rx full", uart_rx_ready, 0);
    hwrite(4'h0, 8'h05);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = 8'h80 + 8'(i ^ 8);
      hread(4'h8, d); check(d == e, "R5 swapped order", d, e);
    end
    hwrite(4'h0, 8'h04);

    // R8 flush
    uart_tx_ready = 0;
    hwrite(4'h8, 8'hC1); hwrite(4'h8, 8'hC2);
    rx_push(8'hD1); rx_push(8'hD2);
    hwrite(4'h2, 8'h00);
    check(uart_tx_valid == 0, "R8 tx empty after flush", uart_tx_valid, 0);
    hread(4'h8, d); check(d == 8'h00, "R8 rx empty after flush", d, 0);
    uart_tx_ready = 1; idle(4);
    check(uart_tx_valid == 0 && exp_q.size() == 0, "R8 no tx after flush", uart_tx_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule